// File: doc/BRIEF.md
# I/O Expander Register Access Monitor

This block sits beside an I2C bus decoder and follows, one event at a time, the transactions that a controller makes to an 8-bit I/O expander. Each incoming event carries a kind code and a byte, qualified by a valid strobe. From that stream the monitor finds the register the controller points at, reports every byte written to or read from that register, and flags transactions aimed at an address the expander cannot have.

Writes to the output-port register are copied onto an 8-bit mirror, so a waveform or downstream logic can see the expander's pin drive without decoding the bus again. The monitor never drives the bus. It only observes the events that an upstream bit-level decoder has already produced.

Top module: `i2c_expander_monitor`

## Requirements
- R1: Event kind codes on `ev_kind` are 0 START, 1 repeated START, 2 address-read, 3 address-write, 4 data-write, 5 data-read, 6 STOP, and 7 is unused. While idle, every event except START is ignored and produces no output.
- R2: After START, the next valid event of any kind is consumed as the target address. The events that follow belong to the register-pointer phase.
- R3: In the register-pointer phase, an address-read or address-write event whose byte is neither 0x20 nor 0x21 pulses `warn` and returns the monitor to idle. With 0x20 or 0x21 the monitor stays in the pointer phase and gives no output.
- R4: The first data-write in the pointer phase becomes the register pointer and the monitor enters the write phase. For pointer values 0 to 3 (0 input, 1 output, 2 polarity, 3 configuration), `sel_valid` pulses with `sel_index` equal to the pointer. For larger values there is no select pulse.
- R5: In the write phase, each data-write pulses `val_valid` with `val_index` equal to the pointer and `val_data` equal to the byte. STOP returns the monitor to idle. All other event kinds except repeated START are ignored.
- R6: A write-phase data-write while the pointer is 1 loads the byte into `port_out`, with bit i driving pin i. No other event changes `port_out`.
- R7: A repeated START in the write phase makes the monitor wait for an address-read, ignoring all other events. After the address-read, each data-read is reported as a value of the pointer register, and STOP returns the monitor to idle.
- R8: With a pointer above 3, each data-write or data-read that would be reported pulses `warn` instead, and no value report is made.
- R9: `sel_valid`, `val_valid` and `warn` are single-cycle pulses, registered one clock after the event that caused them. No pulse follows a cycle without `ev_valid`.
- R10: A synchronous reset returns the monitor to idle, clears the stored pointer, drives all pulses low and sets `port_out` to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event kind code |
| ev_byte | input | 8 | Byte carried by the event |
| sel_valid | output | 1 | Register-select report pulse |
| sel_index | output | 2 | Selected register index |
| val_valid | output | 1 | Register-value report pulse |
| val_index | output | 2 | Register the value belongs to |
| val_data | output | 8 | Reported register value |
| warn | output | 1 | Bad address or undefined register pulse |
| port_out | output | 8 | Mirror of the last output-port write |

## Verification
The hardest state to reach is the read path, because it needs a full write preamble, a repeated START and an address-read, and events that should be ignored in the waiting state must be told apart from ones that are consumed. The stimulus sweeps every pointer value from 0 to 7 through the complete write-then-read transaction and inserts stray events at each phase. It also sweeps all 256 bytes as the pointer-phase address, and after each one probes with a data-write to show whether the monitor really went back to idle.

// File: rtl/i2c_expander_monitor.sv
module i2c_expander_monitor #(
  parameter logic [7:0] ADDR_LO = 8'h20,
  parameter logic [7:0] ADDR_HI = 8'h21,
  parameter int NUM_REGS = 4,
  parameter int OUT_REG = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       sel_valid,
  output logic [1:0] sel_index,
  output logic       val_valid,
  output logic [1:0] val_index,
  output logic [7:0] val_data,
  output logic       warn,
  output logic [7:0] port_out
);
  localparam logic [2:0] K_START = 3'd0, K_RSTART = 3'd1, K_ADRD = 3'd2,
                         K_ADWR = 3'd3, K_DWR = 3'd4, K_DRD = 3'd5, K_STOP = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_TARGET, S_POINTER, S_WRITE, S_RWAIT, S_READ} state_t;

  state_t     state;
  logic [1:0] ptr;
  logic       ptr_ok;

  wire byte_in_range = ev_byte < 8'(NUM_REGS);
  wire addr_event    = (ev_kind == K_ADRD) || (ev_kind == K_ADWR);
  wire addr_good     = (ev_byte == ADDR_LO) || (ev_byte == ADDR_HI);
  wire report_wr     = (state == S_WRITE) && (ev_kind == K_DWR);
  wire report_rd     = (state == S_READ) && (ev_kind == K_DRD);
  wire report        = ev_valid && (report_wr || report_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ptr       <= '0;
      ptr_ok    <= 1'b0;
      sel_valid <= 1'b0;
      sel_index <= '0;
      val_valid <= 1'b0;
      val_index <= '0;
      val_data  <= '0;
      warn      <= 1'b0;
      port_out  <= '0;
    end else begin
      sel_valid <= 1'b0;
      val_valid <= 1'b0;
      warn      <= 1'b0;
      if (report) begin
        if (ptr_ok) begin
          val_valid <= 1'b1;
          val_index <= ptr;
          val_data  <= ev_byte;
          if (report_wr && ptr == 2'(OUT_REG))
            port_out <= ev_byte;
        end else begin
          warn <= 1'b1;
        end
      end
      if (ev_valid) begin
        case (state)
          S_IDLE:
            if (ev_kind == K_START) state <= S_TARGET;
          S_TARGET:
            state <= S_POINTER;
          S_POINTER:
            if (addr_event && !addr_good) begin
              warn  <= 1'b1;
              state <= S_IDLE;
            end else if (ev_kind == K_DWR) begin
              ptr    <= ev_byte[1:0];
              ptr_ok <= byte_in_range;
              if (byte_in_range) begin
                sel_valid <= 1'b1;
                sel_index <= ev_byte[1:0];
              end
              state <= S_WRITE;
            end
          S_WRITE:
            if (ev_kind == K_RSTART) state <= S_RWAIT;
            else if (ev_kind == K_STOP) state <= S_IDLE;
          S_RWAIT:
            if (ev_kind == K_ADRD) state <= S_READ;
          S_READ:
            if (ev_kind == K_STOP) state <= S_IDLE;
          default:
            state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_expander_monitor_chk.sv
module i2c_expander_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_valid,
  input logic [2:0] ev_kind,
  input logic       sel_valid,
  input logic       val_valid,
  input logic       warn,
  input logic [7:0] port_out
);
  AST_NO_PULSE_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !(sel_valid || val_valid || warn)); // R9
  AST_WARN_EXCLUDES_REPORTS: assert property (@(posedge clk) disable iff (rst)
    !(warn && (sel_valid || val_valid))); // R8
  AST_SEL_EXCLUDES_VALUE: assert property (@(posedge clk) disable iff (rst)
    !(sel_valid && val_valid)); // R4
  AST_MIRROR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && ev_kind == 3'd4) |=> $stable(port_out)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (port_out == 8'h00) && !sel_valid && !val_valid && !warn); // R10
endmodule

bind i2c_expander_monitor i2c_expander_monitor_chk u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
  .sel_valid(sel_valid), .val_valid(val_valid), .warn(warn), .port_out(port_out)
);

// File: tb/i2c_expander_monitor_tb.sv
module i2c_expander_monitor_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'd0;
  logic       sel_valid, val_valid, warn;
  logic [1:0] sel_index, val_index;
  logic [7:0] val_data, port_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_mir = 8'h00;

  i2c_expander_monitor u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .sel_valid(sel_valid), .sel_index(sel_index), .val_valid(val_valid),
    .val_index(val_index), .val_data(val_data), .warn(warn), .port_out(port_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic send(input logic [2:0] k, input logic [7:0] b);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 3'd7; ev_byte = 8'h00;
  endtask

  task automatic chk(input logic s, input logic [1:0] si, input logic v,
                     input logic [1:0] vi, input logic [7:0] vd, input logic w,
                     input string tag);
    logic bad;
    bad = (sel_valid !== s) || (s && sel_index !== si) || (val_valid !== v) ||
          (v && (val_index !== vi || val_data !== vd)) || (warn !== w) ||
          (port_out !== exp_mir);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: got sel=%b/%0d val=%b/%0d/%h warn=%b mir=%h, expected sel=%b/%0d val=%b/%0d/%h warn=%b mir=%h",
               tag, sel_valid, sel_index, val_valid, val_index, val_data, warn, port_out,
               s, si, v, vi, vd, w, exp_mir);
    end
  endtask

  task automatic none(input string tag);
    chk(1'b0, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    none("R10 reset state");
    rst = 1'b0;
    @(negedge clk);

    // R1: idle ignores everything but START
    for (int k = 1; k < 8; k++) begin
      send(3'(k), 8'h01);
      none("R1 idle ignore");
    end
    send(3'd0, 8'h00); none("R2 start");
    send(3'd4, 8'h77); none("R2 any event is target");
    send(3'd4, 8'h02); chk(1'b1, 2'd2, 1'b0, 2'd0, 8'h00, 1'b0, "R1 R2 alignment select");
    send(3'd6, 8'h00); none("R5 stop");

    // R4 R5 R6 R7 R8: every pointer through write and read paths
    for (int p = 0; p < 8; p++) begin
      logic ok;
      ok = (p < 4);
      send(3'd0, 8'h00); none("R2 start");
      send(3'd3, 8'h20); none("R2 target");
      send(3'd3, 8'h21); none("R3 good address stays");
      send(3'd4, 8'(p)); chk(ok, 2'(p), 1'b0, 2'd0, 8'h00, 1'b0, "R4 select");
      for (int j = 0; j < 3; j++) begin
        logic [7:0] d;
        d = 8'(p * 37 + j * 91 + 5);
        send(3'd4, d);
        if (ok && p == 1) exp_mir = d;
        chk(1'b0, 2'd0, ok, 2'(p), d, !ok, ok ? "R5 R6 write value" : "R8 write warn");
      end
      send(3'd5, 8'hEE); none("R5 ignored in write");
      send(3'd1, 8'h00); none("R7 restart");
      send(3'd5, 8'hCC); none("R7 wait ignores data");
      send(3'd6, 8'h00); none("R7 wait ignores stop");
      send(3'd2, 8'h21); none("R7 address read");
      for (int j = 0; j < 2; j++) begin
        logic [7:0] d;
        d = 8'(p * 13 + j * 200 + 3);
        send(3'd5, d);
        chk(1'b0, 2'd0, ok, 2'(p), d, !ok, ok ? "R7 read value" : "R8 read warn");
      end
      send(3'd4, 8'h5A); none("R6 read path write ignored");
      send(3'd6, 8'h00); none("R7 stop");
      send(3'd5, 8'h11); none("R1 idle after stop");
    end

    // R3: sweep all addresses in the pointer phase
    for (int a = 0; a < 256; a++) begin
      logic w;
      w = (a != 8'h20) && (a != 8'h21);
      send(3'd0, 8'h00);
      send(3'd3, 8'h40);
      send(3'((a % 2 == 0) ? 3 : 2), 8'(a));
      chk(1'b0, 2'd0, 1'b0, 2'd0, 8'h00, w, "R3 address check");
      send(3'd4, 8'h03);
      chk(!w, 2'd3, 1'b0, 2'd0, 8'h00, 1'b0, "R3 return to idle");
      send(3'd6, 8'h00);
    end

    // R10: mid-transaction reset
    send(3'd0, 8'h00); send(3'd3, 8'h20); send(3'd4, 8'h01);
    send(3'd4, 8'hA5); exp_mir = 8'hA5;
    chk(1'b0, 2'd0, 1'b1, 2'd1, 8'hA5, 1'b0, "R6 mirror load");
    rst = 1'b1; @(negedge clk); rst = 1'b0; exp_mir = 8'h00;
    none("R10 mirror cleared");
    send(3'd4, 8'h5C); none("R10 idle after reset");
    send(3'd5, 8'h5C); none("R10 idle after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule